// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link, working in clock mode 0, placed in front of a byte-wide storage array. The host frames each exchange with an active-low select. Every transfer moves most significant bit first. The block samples SI on rising serial-clock edges and changes SO on falling ones. The first byte of a frame is a command code. A read or write command is then followed by a two-byte address and a stream of data bytes. The block decodes the command, runs the address counter, and moves data between the link and a storage port whose read data depends only on the address it is given. Three parts stay outside the block: the write-cycle timer, the protection policy, and the status byte. The block reaches them through `busy`, `wr_grant`, `stat_in`, the command strobe and the end-of-frame pulse.

All link pins pass through two-flop synchronizers into `clk`. `clk` must run at least four times faster than the serial clock, and all edges are detected in the `clk` domain. SO is given as a data bit plus a separate output enable, so the drive can be tri-stated at the pad. The controller is a single state machine with these states. ST_IDLE waits for select. ST_OPC collects the command byte. ST_ADDR collects two address bytes. ST_RDAT streams array data. ST_WDAT takes in write data. ST_SRD streams the status byte. ST_SWR takes the status write byte. ST_LOCK ignores the rest of the frame. Its transitions are these:
- A select fall moves any state to ST_OPC.
- Select high moves any state to ST_IDLE.
- In ST_OPC, a finished command byte moves to ST_ADDR for read, or for write when granted. It moves to ST_SRD for status read and to ST_SWR for status write. Every other code goes to ST_LOCK.
- In ST_ADDR, the second address byte moves to ST_RDAT or ST_WDAT.
- In ST_SWR, a finished byte moves to ST_LOCK.

Top module: `spi_ee_front`

## Requirements
- R1: A frame starts only on a falling edge of `cs_n`. While `cs_n` is high, `so_oe` is 0 and SI bits have no effect. Each rising edge of `cs_n` gives a one-cycle `frame_end` pulse.
- R2: A command byte is recognised only when its upper four bits are 0, and bit 3 is ignored. Low three bits 110 are write-enable, 100 write-disable, 101 status read, 001 status write, 011 read and 010 write. Write-enable and write-disable each give one `cmd_valid` pulse, with `cmd_kind` 0 and 1 respectively.
- R3: After an unrecognised command byte, no strobe is produced and `so_oe` stays 0 until the next `cs_n` fall. This holds even if valid codes follow in the same frame.
- R4: A read takes a 16-bit address, high byte first. It then shifts out the addressed byte MSB first, with each bit valid before the following rising edge, and continues with the next address for as long as the clock runs.
- R5: A sequential read wraps from address DEPTH-1 to address 0.
- R6: Address bits at and above log2(DEPTH) are ignored.
- R7: A write command issued while `wr_grant` is 1 gives one `mem_we` pulse per received data byte. Each pulse carries `mem_wdata` and the current `mem_addr`, and the address advances by one after every pulse. If `wr_grant` is 0 when the command byte completes, the frame is ignored.
- R8: A status read shifts out `stat_in` MSB first and repeats it for each further byte.
- R9: A status write gives one `cmd_valid` pulse with `cmd_kind` 2 and `cmd_data` equal to the byte that follows the command.
- R10: While `busy` is 1, every command except status read is ignored: no strobe, and no SO drive.
- R11: A change of `hold_n` takes effect only while the serial clock is low. While the hold is active, `so_oe` is 0 and serial clock edges and SI are ignored. Once the hold is released, the frame continues at the same bit position.
- R12: After reset, `so_oe`, `mem_we`, `cmd_valid` and `frame_end` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for SO |
| busy | input | 1 | Internal write cycle in progress |
| wr_grant | input | 1 | Array writes permitted |
| stat_in | input | 8 | Status byte to shift out |
| mem_addr | output | log2(DEPTH) | Storage address |
| mem_rdata | input | 8 | Storage data for `mem_addr`, same cycle |
| mem_we | output | 1 | Storage write strobe |
| mem_wdata | output | 8 | Storage write data |
| cmd_valid | output | 1 | Command strobe |
| cmd_kind | output | 2 | 0 write-enable, 1 write-disable, 2 status write |
| cmd_data | output | 8 | Status write byte |
| frame_end | output | 1 | Pulse on rising edge of select |

## Verification
The assertions assume the link inputs change slowly compared with `clk`: each serial clock level lasts several system clocks, and `cs_n` and `hold_n` change only while the serial clock is low. Under those conditions, a write strobe and a command strobe can never fall in the same cycle as an end of frame. The bench keeps to this by using 40 ns serial half-periods on a 5 ns clock. It changes SI, select and hold only with the serial clock low, and leaves settling time around every select and hold change.

// File: rtl/spi_ee_pkg.sv
`timescale 1ns/1ps
package spi_ee_pkg;
    typedef enum logic [2:0] {
        OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE, OP_BAD
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_SWR, ST_LOCK
    } st_e;

    typedef enum logic [1:0] {
        CMD_WREN = 2'd0, CMD_WRDI = 2'd1, CMD_WRSR = 2'd2
    } cmd_e;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= {2{RST_VAL[i]}};
            else        ff <= {ff[0], d[i]};
        end
        assign q[i] = ff[1];
    end
endmodule

// File: rtl/spi_op_decode.sv
`timescale 1ns/1ps
module spi_op_decode
    import spi_ee_pkg::*;
(
    input  logic [7:0] code,
    output op_e        op
);
    always_comb begin
        op = OP_BAD;
        if (code[7:4] == 4'h0) begin
            unique case (code[2:0])
                3'b110:  op = OP_WREN;
                3'b100:  op = OP_WRDI;
                3'b101:  op = OP_RDSR;
                3'b001:  op = OP_WRSR;
                3'b011:  op = OP_READ;
                3'b010:  op = OP_WRITE;
                default: op = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/spi_ee_front.sv
`timescale 1ns/1ps
module spi_ee_front
    import spi_ee_pkg::*;
#(
    parameter  int DEPTH = 32768,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          si,
    input  logic          hold_n,
    output logic          so_data,
    output logic          so_oe,
    input  logic          busy,
    input  logic          wr_grant,
    input  logic [7:0]    stat_in,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic          mem_we,
    output logic [7:0]    mem_wdata,
    output logic          cmd_valid,
    output logic [1:0]    cmd_kind,
    output logic [7:0]    cmd_data,
    output logic          frame_end
);
    // synchronised pins: {hold_n, si, cs_n, sck}
    logic [3:0] syn;
    spi_pin_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({hold_n, si, cs_n, sck}), .q(syn)
    );
    logic s_sck, s_cs, s_si, s_hold;
    assign {s_hold, s_si, s_cs, s_sck} = syn;

    st_e          state_q, state_d;
    logic         sck_prev, cs_prev, held_q, so_live, rd_mode, hi_done;
    logic [2:0]   cnt_q;
    logic [7:0]   sh_q, hi_q, wdata_q, cdata_q;
    logic [AW-1:0] addr_q;
    logic         so_q, we_q, cval_q, fend_q;
    cmd_e         kind_q;

    logic sck_rise, sck_fall, cs_fall, cs_rise, active, bit_rise, bit_fall;
    logic byte_done, talk;
    logic [7:0] byte_in, tx_src;
    op_e  op;

    assign sck_rise  = s_sck & ~sck_prev;
    assign sck_fall  = ~s_sck & sck_prev;
    assign cs_fall   = ~s_cs & cs_prev;
    assign cs_rise   = s_cs & ~cs_prev;
    assign active    = ~s_cs & ~held_q & (state_q != ST_IDLE) & (state_q != ST_LOCK);
    assign bit_rise  = sck_rise & active;
    assign bit_fall  = sck_fall & active;
    assign byte_done = bit_rise & (cnt_q == 3'd7);
    assign byte_in   = {sh_q[6:0], s_si};
    assign talk      = (state_q == ST_RDAT) || (state_q == ST_SRD);
    assign tx_src    = (state_q == ST_SRD) ? stat_in : mem_rdata;

    spi_op_decode u_dec (.code(byte_in), .op(op));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (s_cs) begin
            state_d = ST_IDLE;
        end else if (cs_fall) begin
            state_d = ST_OPC;
        end else begin
            unique case (state_q)
                ST_OPC: if (byte_done) begin
                    if (op == OP_BAD || (busy && op != OP_RDSR)) state_d = ST_LOCK;
                    else if (op == OP_READ)  state_d = ST_ADDR;
                    else if (op == OP_WRITE) state_d = wr_grant ? ST_ADDR : ST_LOCK;
                    else if (op == OP_RDSR)  state_d = ST_SRD;
                    else if (op == OP_WRSR)  state_d = ST_SWR;
                    else                     state_d = ST_LOCK;
                end
                ST_ADDR: if (byte_done && hi_done) state_d = rd_mode ? ST_RDAT : ST_WDAT;
                ST_SWR:  if (byte_done) state_d = ST_LOCK;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;  cs_prev <= 1'b1;  held_q <= 1'b0;
            so_live  <= 1'b0;  rd_mode <= 1'b0;  hi_done <= 1'b0;
            cnt_q    <= '0;    sh_q    <= '0;    hi_q    <= '0;
            addr_q   <= '0;    so_q    <= 1'b0;  we_q    <= 1'b0;
            wdata_q  <= '0;    cval_q  <= 1'b0;  kind_q  <= CMD_WREN;
            cdata_q  <= '0;    fend_q  <= 1'b0;
        end else begin
            sck_prev <= s_sck;
            cs_prev  <= s_cs;
            we_q     <= 1'b0;
            cval_q   <= 1'b0;
            fend_q   <= cs_rise;
            if (s_cs)        held_q <= 1'b0;
            else if (!s_sck) held_q <= ~s_hold;
            if (we_q) addr_q <= addr_q + 1'b1;
            if (cs_fall) begin
                cnt_q   <= '0;
                hi_done <= 1'b0;
                so_live <= 1'b0;
            end else begin
                if (bit_rise) begin
                    sh_q  <= byte_in;
                    cnt_q <= cnt_q + 1'b1;
                end
                if (byte_done) begin
                    unique case (state_q)
                        ST_OPC: begin
                            rd_mode <= (op == OP_READ);
                            if (!busy && (op == OP_WREN || op == OP_WRDI)) begin
                                cval_q <= 1'b1;
                                kind_q <= (op == OP_WREN) ? CMD_WREN : CMD_WRDI;
                            end
                        end
                        ST_ADDR: begin
                            if (!hi_done) begin
                                hi_q    <= byte_in;
                                hi_done <= 1'b1;
                            end else begin
                                addr_q <= AW'({hi_q, byte_in});
                            end
                        end
                        ST_RDAT: addr_q <= addr_q + 1'b1;
                        ST_WDAT: begin
                            we_q    <= 1'b1;
                            wdata_q <= byte_in;
                        end
                        ST_SWR: begin
                            cval_q  <= 1'b1;
                            kind_q  <= CMD_WRSR;
                            cdata_q <= byte_in;
                        end
                        default: ;
                    endcase
                end
                if (bit_fall && talk) begin
                    so_q    <= tx_src[~cnt_q];
                    so_live <= 1'b1;
                end
            end
        end
    end

    assign so_data   = so_q;
    assign so_oe     = so_live & talk & ~held_q & ~s_cs;
    assign mem_addr  = addr_q;
    assign mem_we    = we_q;
    assign mem_wdata = wdata_q;
    assign cmd_valid = cval_q;
    assign cmd_kind  = kind_q;
    assign cmd_data  = cdata_q;
    assign frame_end = fend_q;
endmodule

// File: rtl/spi_ee_chk.sv
`timescale 1ns/1ps
module spi_ee_chk
    import spi_ee_pkg::*;
#(
    parameter int AW = 15
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          so_oe,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          cmd_valid,
    input logic          frame_end,
    input st_e           state_q
);
    assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);

    assert_frame_end_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

    assert_strobes_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, cmd_valid, frame_end}));

    assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK) |=> (state_q inside {ST_LOCK, ST_IDLE, ST_OPC}) && !mem_we);

    assert_we_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_we_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));
endmodule

bind spi_ee_front spi_ee_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .mem_we(mem_we),
    .mem_addr(mem_addr), .cmd_valid(cmd_valid), .frame_end(frame_end),
    .state_q(state_q)
);

// File: tb/tb_spi_ee_front.sv
`timescale 1ns/1ps
module tb_spi_ee_front;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic busy = 1'b0, wr_grant = 1'b1;
    logic [7:0] stat_in = 8'h8C;
    logic so_data, so_oe, mem_we, cmd_valid, frame_end;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata, mem_wdata, cmd_data;
    logic [1:0] cmd_kind;

    spi_ee_front #(.DEPTH(DEPTH)) dut (.*);

    // storage model owned by the bench
    logic [7:0] mem [DEPTH];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    int n_chk = 0, n_err = 0, n_fe = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic       wr;
        logic [1:0] kind;
        logic [7:0] addr;
        logic [7:0] data;
    } item_t;
    item_t exp_q[$];
    string tag_q[$];

    task automatic expect_item(input string tag, input logic wr, input logic [1:0] kind,
                               input logic [7:0] addr, input logic [7:0] data);
        exp_q.push_back('{wr: wr, kind: kind, addr: addr, data: data});
        tag_q.push_back(tag);
    endtask

    // monitor: pops the scoreboard as strobes appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_end) n_fe++;
            if (mem_we || cmd_valid) begin
                item_t got, e;
                string t;
                got.wr   = mem_we;
                got.kind = mem_we ? 2'd0 : cmd_kind;
                got.addr = mem_we ? mem_addr : 8'h00;
                got.data = mem_we ? mem_wdata : ((cmd_kind == 2'd2) ? cmd_data : 8'h00);
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R3/R7/R10 unexpected strobe got=%h expected none", got);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (got !== e) begin
                        n_err++;
                        $display("FAIL %s strobe got=%h expected=%h", t, got, e);
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic bitx(input logic b, output logic o, output logic oe);
        si = b;
        #40;
        o  = so_data;
        oe = so_oe;
        sck = 1'b1;
        #40;
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_all, output logic oe_any);
        logic o, oe;
        oe_all = 1'b1;
        oe_any = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            bitx(tx[i], o, oe);
            rx[i]  = o;
            oe_all &= oe;
            oe_any |= oe;
        end
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        #40;
    endtask

    task automatic cs_hi();
        #40;
        cs_n = 1'b1;
        #120;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rx;
        logic oa, on, o, oe;
        int fe0;

        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        check("R12 reset outputs", {so_oe, mem_we, cmd_valid, frame_end}, 4'b0000);

        // R2: write-enable, with and without bit 3, and write-disable
        fe0 = n_fe;
        expect_item("R2 wren", 1'b0, 2'd0, 8'h00, 8'h00);
        cs_lo(); xfer(8'h06, rx, oa, on); cs_hi();
        check("R1 one frame_end per frame", n_fe - fe0, 1);
        expect_item("R2 wren bit3 set", 1'b0, 2'd0, 8'h00, 8'h00);
        cs_lo(); xfer(8'h0E, rx, oa, on); cs_hi();
        expect_item("R2 wrdi", 1'b0, 2'd1, 8'h00, 8'h00);
        cs_lo(); xfer(8'h04, rx, oa, on); cs_hi();

        // R9: status write
        expect_item("R9 wrsr", 1'b0, 2'd2, 8'h00, 8'h0C);
        cs_lo(); xfer(8'h01, rx, oa, on); xfer(8'h0C, rx, oa, on); cs_hi();

        // R7: two-byte write at 0x10
        expect_item("R7 write byte0", 1'b1, 2'd0, 8'h10, 8'hA5);
        expect_item("R7 write byte1", 1'b1, 2'd0, 8'h11, 8'h3C);
        cs_lo();
        xfer(8'h02, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h10, rx, oa, on);
        xfer(8'hA5, rx, oa, on); xfer(8'h3C, rx, oa, on);
        cs_hi();

        // R4: read back, continuing into an untouched address
        cs_lo();
        xfer(8'h03, rx, oa, on); check("R4 so off during command", on, 1'b0);
        xfer(8'h00, rx, oa, on); xfer(8'h10, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R4 read byte0", rx, 8'hA5);
        check("R4 so driven during data", oa, 1'b1);
        xfer(8'h00, rx, oa, on); check("R4 read byte1", rx, 8'h3C);
        xfer(8'h00, rx, oa, on); check("R4 read byte2", rx, init_val(8'h12));
        cs_hi();
        check("R1 so off after deselect", so_oe, 1'b0);

        // R5: wrap from top address
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'hFF, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R5 read top", rx, init_val(8'hFF));
        xfer(8'h00, rx, oa, on); check("R5 wrap to zero", rx, init_val(0));
        cs_hi();

        // R6: high address bits ignored
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'hAB, rx, oa, on); xfer(8'h10, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R6 upper address ignored", rx, 8'hA5);
        cs_hi();

        // R3: invalid codes lock the frame
        cs_lo();
        xfer(8'h07, rx, oa, on);
        begin
            logic any;
            any = on;
            xfer(8'h02, rx, oa, on); any |= on;
            xfer(8'h06, rx, oa, on); any |= on;
            xfer(8'h03, rx, oa, on); any |= on;
            check("R3 so stays off after bad code", any, 1'b0);
        end
        cs_hi();
        cs_lo(); xfer(8'h12, rx, oa, on); xfer(8'h06, rx, oa, on); cs_hi();
        expect_item("R3 next frame decodes", 1'b0, 2'd0, 8'h00, 8'h00);
        cs_lo(); xfer(8'h06, rx, oa, on); cs_hi();

        // R8: status read repeats
        cs_lo();
        xfer(8'h05, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R8 status byte", rx, 8'h8C);
        xfer(8'h00, rx, oa, on); check("R8 status repeats", rx, 8'h8C);
        cs_hi();

        // R10: busy blocks everything but status read
        busy = 1'b1;
        cs_lo(); xfer(8'h06, rx, oa, on); cs_hi();
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h10, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R10 read ignored while busy", on, 1'b0);
        cs_hi();
        cs_lo();
        xfer(8'h02, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h20, rx, oa, on);
        xfer(8'h77, rx, oa, on);
        cs_hi();
        cs_lo();
        xfer(8'h05, rx, oa, on); xfer(8'h00, rx, oa, on);
        check("R10 status read while busy", rx, 8'h8C);
        cs_hi();
        busy = 1'b0;
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h20, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R10 busy write left array", rx, init_val(8'h20));
        cs_hi();

        // R7: no grant, no write
        wr_grant = 1'b0;
        cs_lo();
        xfer(8'h02, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h30, rx, oa, on);
        xfer(8'h99, rx, oa, on);
        cs_hi();
        wr_grant = 1'b1;
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on); xfer(8'h30, rx, oa, on);
        xfer(8'h00, rx, oa, on); check("R7 ungranted write ignored", rx, init_val(8'h30));
        cs_hi();

        // R11: hold in the address phase and in the data phase
        cs_lo();
        xfer(8'h03, rx, oa, on); xfer(8'h00, rx, oa, on);
        for (int i = 7; i >= 4; i--) bitx(1'(8'h11 >> i), o, oe);
        #20; hold_n = 1'b0; #40;
        for (int k = 0; k < 3; k++) begin
            si = 1'b1; sck = 1'b1; #40; sck = 1'b0; #40;
        end
        hold_n = 1'b1; #40;
        for (int i = 3; i >= 0; i--) bitx(1'(8'h11 >> i), o, oe);
        rx = '0;
        for (int i = 7; i >= 5; i--) begin
            bitx(1'b0, o, oe); rx[i] = o;
        end
        #20; hold_n = 1'b0; #40;
        check("R11 so off during hold", so_oe, 1'b0);
        for (int k = 0; k < 2; k++) begin
            si = 1'b1; sck = 1'b1; #40; sck = 1'b0; #40;
        end
        hold_n = 1'b1; #40;
        for (int i = 4; i >= 0; i--) begin
            bitx(1'b0, o, oe); rx[i] = o;
        end
        check("R11 frame resumes after hold", rx, 8'h3C);
        cs_hi();

        // R1: clocking with select high does nothing
        for (int i = 7; i >= 0; i--) begin
            si = 1'(8'h06 >> i); #40; sck = 1'b1; #40; sck = 1'b0;
        end
        #80;
        check("R1 so off while deselected", so_oe, 1'b0);

        #200;
        check("R2 R7 R9 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule